// File: doc/BRIEF.md
# Acknowledgment Receive Buffer

This block stores one incoming acknowledgment frame in a local byte memory, and a host reads that frame back one byte at a time through a small register window. The frame arrives as a byte stream. Each byte comes with a valid strobe, and start and end markers mark the frame boundaries. When the last byte is accepted, the block emits a one-cycle done pulse, which is meant to drive an interrupt register elsewhere.

The host arms the buffer by setting an enable bit. Setting that bit also rewinds the read pointer. The block clears the enable bit itself at the end of each frame, so the stored bytes cannot be overwritten until the host arms the buffer again. Reads of the data port advance the pointer automatically, which gives FIFO-style access. The host can also load the pointer with any value for random access.

A length register reports the size of the whole frame, FCS included, and saturates at 255. The memory keeps only the first 128 bytes of a frame, but every byte is counted. A length from 129 to 132 therefore means that only FCS bytes were lost. A larger length means payload bytes were lost.

Top module: `ack_rx_buffer`

## Requirements
- R1: After synchronous reset, the enable bit and the read pointer are 0, `frame_done` is 0 and `reg_rdata` is 0. The register offsets are 0 for the pointer (read/write, 7-bit value in bits 6:0), 1 for the data port (read only), 2 for the length (read only) and 3 for control (enable in bit 0).
- R2: While the enable bit is 0, incoming bytes are ignored. Memory contents and the length stay unchanged and no done pulse occurs.
- R3: While enabled, the bytes of a frame, starting with the byte flagged by `rx_sof`, are stored at memory locations 0, 1, 2 and onward. `frame_done` is high for exactly one cycle, the cycle after the clock edge that accepts the byte flagged by `rx_eof`.
- R4: The enable bit reads 0 once the done pulse has been issued.
- R5: A read of the data port returns, one cycle later, the byte at the current pointer, and the pointer then increments. The pointer wraps from 127 to 0.
- R6: A host write to the pointer register sets the location of the next data-port read.
- R7: A host write of 1 to the enable bit resets the pointer to 0.
- R8: The length register holds the total number of bytes in the frame, saturating at 255. Bytes past location 127 are not stored and leave locations 0 to 127 unchanged.
- R9: For a frame of 129 to 132 bytes, the length reports the exact count and all of the first 128 bytes can be read back.
- R10: While enabled but outside a frame, bytes that are not flagged with `rx_sof` are ignored, including a stray `rx_eof`.
- R11: `reg_rdata` changes only in the cycle after a register read. Idle cycles and host writes leave it unchanged.
- R12: If the host clears the enable bit in the middle of a frame, the frame is abandoned and no done pulse is issued for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_vld | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of frame (with rx_vld) |
| rx_eof | input | 1 | Last byte of frame (with rx_vld) |
| rx_data | input | 8 | Receive byte |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 2 | Host register offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, valid the cycle after reg_rd |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench checks for a second frame that is sent while the buffer is disarmed. A design that does not lock the write side would overwrite the first frame and pulse done again. Frames of 130 and 300 bytes probe the 128-byte memory limit and the saturating length. A design that lets the write address wrap would corrupt location 0, and a design with a plain counter would report 44 instead of 255. Stray bytes before a start marker, a mid-frame disarm and a pointer that wraps past 127 are each exercised, because a design without a proper idle state would store noise, finish an abandoned frame, or read from out-of-range locations.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam logic [1:0] OFS_PTR  = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;
  localparam logic [1:0] OFS_LEN  = 2'd2;
  localparam logic [1:0] OFS_CTL  = 2'd3;
  localparam int         CTL_EN_BIT = 0;
endpackage

// File: rtl/rxbuf_ram.sv
module rxbuf_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata_q
);
  logic [DW-1:0] mem [DEPTH];

  // write port: no reset so the array maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port with synchronous output reset
  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (re) rdata_q <= mem[raddr];
  end
endmodule

// File: rtl/rxbuf_capture.sv
module rxbuf_capture #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  parameter int AW    = 7,
  parameter int LW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          rx_vld,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic [DW-1:0] rx_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic          frame_end,
  output logic          done_q,
  output logic [LW-1:0] len_q
);
  typedef enum logic {ST_IDLE, ST_BODY} st_e;

  localparam logic [LW-1:0] LEN_MAX = '1;
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  st_e           st_q;
  logic [LW-1:0] cnt_q;
  logic [LW-1:0] idx;
  logic [LW-1:0] cnt_nxt;
  logic          accept;

  always_comb begin
    accept    = rx_vld && arm && (rx_sof || (st_q == ST_BODY));
    idx       = rx_sof ? '0 : cnt_q;
    cnt_nxt   = (idx == LEN_MAX) ? idx : idx + 1'b1;
    mem_we    = accept && (idx < DEPTH_L);
    mem_waddr = idx[AW-1:0];
    mem_wdata = rx_data;
    frame_end = accept && rx_eof;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= frame_end;
      if (!arm) begin
        st_q <= ST_IDLE;
      end else if (accept) begin
        st_q  <= rx_eof ? ST_IDLE : ST_BODY;
        cnt_q <= cnt_nxt;
      end
    end
  end

  // length is committed only at end of frame; not touched by reset
  always_ff @(posedge clk) begin
    if (frame_end) len_q <= cnt_nxt;
  end
endmodule

// File: rtl/rxbuf_host.sv
module rxbuf_host
  import rxbuf_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          frame_end,
  input  logic [LW-1:0] len_q,
  input  logic [DW-1:0] ram_q,
  output logic          en_q,
  output logic [AW-1:0] rd_ptr,
  output logic          ram_re,
  output logic [DW-1:0] reg_rdata
);
  logic [1:0]    sel_q;
  logic [DW-1:0] hold_q;
  logic          wr_ptr;
  logic          wr_ctl;
  logic          arm_req;

  always_comb begin
    wr_ptr  = reg_wr && (reg_addr == OFS_PTR);
    wr_ctl  = reg_wr && (reg_addr == OFS_CTL);
    arm_req = wr_ctl && reg_wdata[CTL_EN_BIT];
    ram_re  = reg_rd && (reg_addr == OFS_DATA);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      en_q   <= 1'b0;
      sel_q  <= OFS_PTR;
      hold_q <= '0;
    end else begin
      if (wr_ptr)       rd_ptr <= reg_wdata[AW-1:0];
      else if (arm_req) rd_ptr <= '0;
      else if (ram_re)  rd_ptr <= rd_ptr + 1'b1;

      if (wr_ctl)         en_q <= reg_wdata[CTL_EN_BIT];
      else if (frame_end) en_q <= 1'b0;

      if (reg_rd) begin
        sel_q <= reg_addr;
        case (reg_addr)
          OFS_PTR: hold_q <= DW'(rd_ptr);
          OFS_LEN: hold_q <= DW'(len_q);
          OFS_CTL: begin
            hold_q             <= '0;
            hold_q[CTL_EN_BIT] <= en_q;
          end
          default: hold_q <= hold_q;
        endcase
      end
    end
  end

  assign reg_rdata = (sel_q == OFS_DATA) ? ram_q : hold_q;
endmodule

// File: rtl/ack_rx_buffer.sv
module ack_rx_buffer #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  parameter int LW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_vld,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic [DW-1:0] rx_data,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          frame_done
);
  localparam int AW = $clog2(DEPTH);

  logic          en_q;
  logic [AW-1:0] rd_ptr;
  logic          ram_re;
  logic [DW-1:0] ram_q;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;
  logic          frame_end;
  logic [LW-1:0] len_q;

  rxbuf_capture #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .LW(LW)) u_cap (
    .clk(clk), .rst(rst), .arm(en_q),
    .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .frame_end(frame_end), .done_q(frame_done), .len_q(len_q)
  );

  rxbuf_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .rst(rst),
    .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(ram_re), .raddr(rd_ptr), .rdata_q(ram_q)
  );

  rxbuf_host #(.DW(DW), .AW(AW), .LW(LW)) u_host (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .frame_end(frame_end), .len_q(len_q), .ram_q(ram_q),
    .en_q(en_q), .rd_ptr(rd_ptr), .ram_re(ram_re), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/ack_rx_buffer_chk.sv
module ack_rx_buffer_chk
  import rxbuf_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [1:0]    reg_addr,
  input logic [DW-1:0] reg_rdata,
  input logic          frame_done,
  input logic          en_q,
  input logic [AW-1:0] rd_ptr,
  input logic [LW-1:0] len_q
);
  // R3: done is a single-cycle pulse
  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R2: no done can follow a cycle with the buffer disarmed
  assert_locked_no_done_R2: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !frame_done);

  // R4: enable is clear when done is seen, unless the host re-armed on that edge
  assert_self_disarm_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !$past(reg_wr && reg_addr == OFS_CTL)) |-> !en_q);

  // R5: a data-port read advances the pointer by one
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == OFS_DATA && !reg_wr) |=> rd_ptr == AW'($past(rd_ptr) + 1'b1));

  // R8: the length moves only together with a done pulse
  assert_len_on_done_R8: assert property (@(posedge clk) disable iff (rst)
    (len_q != $past(len_q)) |-> frame_done);

  // R11: read data holds without a read strobe
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind ack_rx_buffer ack_rx_buffer_chk #(.DW(DW), .AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .frame_done(frame_done), .en_q(en_q),
  .rd_ptr(rd_ptr), .len_q(len_q)
);

// File: tb/tb_ack_rx_buffer.sv
module tb_ack_rx_buffer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_vld = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_data = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       frame_done;

  int n_tests = 0;
  int n_fail  = 0;
  int done_cnt = 0;
  int exp_done = 0;

  localparam logic [1:0] A_PTR = 2'd0, A_DATA = 2'd1, A_LEN = 2'd2, A_CTL = 2'd3;

  always #4 clk = ~clk;

  ack_rx_buffer dut (
    .clk(clk), .rst(rst), .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_done(frame_done)
  );

  always @(negedge clk) if (!rst && frame_done === 1'b1) done_cnt++;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic beat(input logic s, input logic e, input logic [7:0] d);
    @(negedge clk); rx_vld = 1'b1; rx_sof = s; rx_eof = e; rx_data = d;
  endtask

  task automatic rx_idle();
    @(negedge clk); rx_vld = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  // sends n bytes base+i; checks done timing when armed
  task automatic send_frame(input int n, input logic [7:0] base, input logic armed);
    for (int i = 0; i < n; i++) beat(i == 0, i == n - 1, 8'(base + i));
    rx_idle();
    if (armed) begin
      check("R3 done after eof", frame_done, 1'b1);
      exp_done++;
      @(negedge clk);
      check("R3 done single cycle", frame_done, 1'b0);
    end else begin
      check("R2 no done when disarmed", frame_done, 1'b0);
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 rdata after reset", reg_rdata, 8'h00);
    check("R1 done after reset", frame_done, 1'b0);
    host_read(A_CTL, v); check("R1 enable after reset", v, 8'h00);
    host_read(A_PTR, v); check("R1 pointer after reset", v, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] v;
    host_write(A_CTL, 8'h01);
    send_frame(10, 8'h30, 1'b1);
    host_read(A_CTL, v); check("R4 enable self-clear", v, 8'h00);
    host_read(A_LEN, v); check("R8 length 10", v, 8'd10);
    for (int i = 0; i < 10; i++) begin
      host_read(A_DATA, v); check("R3/R5 sequential byte", v, 8'(8'h30 + i));
    end
    host_read(A_PTR, v); check("R5 pointer after 10 reads", v, 8'd10);
  endtask

  task automatic t_timing();
    logic [7:0] v;
    host_read(A_LEN, v); check("R11 length read", v, 8'd10);
    repeat (4) @(negedge clk);
    check("R11 rdata holds idle", reg_rdata, 8'd10);
    host_write(A_PTR, 8'd3);
    check("R11 rdata holds over write", reg_rdata, 8'd10);
    host_read(A_DATA, v); check("R6 random access byte 3", v, 8'h33);
    host_read(A_PTR, v); check("R5 pointer after random read", v, 8'd4);
  endtask

  task automatic t_locked();
    logic [7:0] v;
    send_frame(6, 8'h90, 1'b0);
    repeat (2) @(negedge clk);
    check("R2 done count unchanged", done_cnt, exp_done);
    host_write(A_PTR, 8'd0);
    host_read(A_DATA, v); check("R2 memory protected", v, 8'h30);
    host_read(A_LEN, v); check("R2 length unchanged", v, 8'd10);
  endtask

  task automatic t_rearm();
    logic [7:0] v;
    host_write(A_PTR, 8'd9);
    host_write(A_CTL, 8'h01);
    host_read(A_PTR, v); check("R7 arm clears pointer", v, 8'd0);
    host_read(A_CTL, v); check("R7 enable set", v, 8'h01);
  endtask

  task automatic t_fcs_loss();
    logic [7:0] v;
    send_frame(130, 8'h40, 1'b1);
    host_read(A_LEN, v); check("R9 length 130", v, 8'd130);
    host_write(A_PTR, 8'd127);
    host_read(A_DATA, v); check("R9 last stored byte", v, 8'hBF);
    host_read(A_PTR, v); check("R5 pointer wraps to 0", v, 8'd0);
    host_read(A_DATA, v); check("R9 first byte", v, 8'h40);
  endtask

  task automatic t_saturate();
    logic [7:0] v;
    host_write(A_CTL, 8'h01);
    send_frame(300, 8'h00, 1'b1);
    host_read(A_LEN, v); check("R8 length saturates", v, 8'd255);
    host_write(A_PTR, 8'd0);
    host_read(A_DATA, v); check("R8 location 0 not overwritten", v, 8'h00);
    host_write(A_PTR, 8'd127);
    host_read(A_DATA, v); check("R8 location 127", v, 8'h7F);
  endtask

  task automatic t_pre_sof();
    logic [7:0] v;
    host_write(A_CTL, 8'h01);
    beat(1'b0, 1'b0, 8'h11);
    beat(1'b0, 1'b1, 8'h12);
    rx_idle();
    check("R10 stray eof gives no done", frame_done, 1'b0);
    send_frame(4, 8'hA0, 1'b1);
    check("R10 one done only", done_cnt, exp_done);
    host_read(A_LEN, v); check("R10 length 4", v, 8'd4);
    host_write(A_PTR, 8'd0);
    host_read(A_DATA, v); check("R10 first stored is sof byte", v, 8'hA0);
    host_write(A_PTR, 8'd3);
    host_read(A_DATA, v); check("R10 byte 3", v, 8'hA3);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    host_write(A_CTL, 8'h01);
    beat(1'b1, 1'b0, 8'h55);
    beat(1'b0, 1'b0, 8'h56);
    rx_idle();
    host_write(A_CTL, 8'h00);
    beat(1'b0, 1'b1, 8'h57);
    rx_idle();
    repeat (2) @(negedge clk);
    check("R12 no done after abort", done_cnt, exp_done);
    host_read(A_LEN, v); check("R12 length unchanged", v, 8'd4);
    host_read(A_CTL, v); check("R12 enable stays clear", v, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_timing();
    t_locked();
    t_rearm();
    t_fcs_loss();
    t_saturate();
    t_pre_sof();
    t_abort();
    check("R3 total done pulses", done_cnt, exp_done);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule